// File: doc/BRIEF.md
# Interrupt Acknowledge Controller

This block settles one read of a group's acknowledge register in a virtual interrupt interface. The entry selector upstream has already picked the highest-priority pending entry, or reported that there is none. This block takes that candidate with the access code of the read, the priority mask, the two binary point values and the highest active priority from the active-priority tracker. It decides whether the reader gets the candidate's virtual ID or the spurious ID.

A grant is issued only when every test in a fixed chain passes. The candidate must exist. Its group must match the group being read. Its priority must lie strictly below the mask. Its preemption level must lie strictly below the highest active priority. The preemption level is the priority with the sub-priority bits cleared, as set by the binary point of the read group. On a grant, the block writes the entry back in the same cycle as the response. The entry becomes active for shared and private interrupts. For message-based interrupts, whose IDs lie above the shared range, the entry is left with no state. In that same cycle the block strobes the tracker with the granted priority and group.

Top module: `iack_ctrl`

## Requirements
- R1: The read group comes from the access code: the value 8 selects group 0, and every other value selects group 1. A grant drives `set_act_grp` to 0 for group 0 and to 1 for group 1.
- R2: When `cand_vld` is low, the response carries the spurious ID, and neither `wb_en` nor `set_act_en` rises.
- R3: When the candidate's group bit (`cand_grp`, 0 for group 0 and 1 for group 1) differs from the read group, the response is the spurious ID with no write-back.
- R4: When `prio_mask` is less than or equal to `cand_prio`, the response is the spurious ID with no write-back. A mask one above the priority allows a grant.
- R5: The preemption level is `cand_prio` with its low N bits cleared. N is `bp0`+1 for group 0 and `bp1` for group 1. When `act_hi_prio` is less than or equal to the level, the response is the spurious ID with no write-back.
- R6: On a grant, `rsp_id` equals `cand_vid`. The block asserts `wb_en` with `wb_idx`, `wb_vid`, `wb_prio` and `wb_grp` copied from the candidate. It asserts `set_act_en` with `set_act_prio` equal to `cand_prio`.
- R7: On a grant, `wb_state` is 2'b10 (active) when `cand_vid` is at most 1019, and 2'b00 (no state) when it is above 1019.
- R8: `rsp_vld` is high for exactly the one cycle after each cycle with `req_vld` high. `wb_en` and `set_act_en` are high only in that same cycle.
- R9: After reset, `rsp_vld`, `wb_en` and `set_act_en` are low.
- R10: The spurious ID is 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | 1 | Acknowledge read request, one cycle |
| req_code | input | CODE_W | Access code of the read; 8 means group 0 |
| cand_vld | input | 1 | Selector found a candidate |
| cand_idx | input | IDX_W | Entry index of the candidate |
| cand_vid | input | ID_W | Candidate virtual ID |
| cand_prio | input | PRIO_W | Candidate priority |
| cand_grp | input | 1 | Candidate group bit |
| cand_state | input | 2 | Candidate state field |
| prio_mask | input | PRIO_W | Priority mask |
| bp0 | input | BP_W | Group 0 binary point |
| bp1 | input | BP_W | Group 1 binary point |
| act_hi_prio | input | PRIO_W | Highest active priority from tracker |
| rsp_vld | output | 1 | Response valid |
| rsp_id | output | ID_W | Returned ID |
| wb_en | output | 1 | Entry write-back enable |
| wb_idx | output | IDX_W | Entry index written |
| wb_vid | output | ID_W | Written virtual ID |
| wb_prio | output | PRIO_W | Written priority |
| wb_grp | output | 1 | Written group bit |
| wb_state | output | 2 | Written state field |
| set_act_en | output | 1 | Tracker set-active strobe |
| set_act_prio | output | PRIO_W | Priority to mark active |
| set_act_grp | output | 1 | Group of the active level |

## Verification
A wrong verdict in the check chain shows up in the single response cycle. Either a real ID appears where 1023 was due, or the reverse, and `wb_en` and `set_act_en` disagree with the returned value at once. A wrong shift in the preemption mask shows only when the active priority falls between the raw priority and its masked level, so the bench places the active priority on both sides of that level. A wrong state update shows up in the same cycle on `wb_state`, tested at the 1019/1020 ID boundary.

// File: rtl/iack_pkg.sv
package iack_pkg;

   // entry state field encoding
   typedef enum logic [1:0] {
      ST_NONE     = 2'b00,
      ST_PEND     = 2'b01,
      ST_ACT      = 2'b10,
      ST_PEND_ACT = 2'b11
   } ent_state_e;

   // interrupt group
   typedef enum logic {
      GRP_ZERO = 1'b0,
      GRP_ONE  = 1'b1
   } grp_e;

endpackage

// File: rtl/iack_grp_decode.sv
module iack_grp_decode #(
   parameter int CODE_W  = 4,
   parameter int G0_CODE = 8
) (
   input  logic [CODE_W-1:0] code,
   output iack_pkg::grp_e    grp
);
   initial begin
      if (CODE_W < 1 || G0_CODE >= (1 << CODE_W))
         $error("iack_grp_decode: G0_CODE does not fit CODE_W");
   end

   always_comb begin
      if (code == CODE_W'(G0_CODE)) grp = iack_pkg::GRP_ZERO;
      else                          grp = iack_pkg::GRP_ONE;
   end
endmodule

// File: rtl/iack_preempt.sv
module iack_preempt #(
   parameter int PRIO_W = 8,
   parameter int BP_W   = 3
) (
   input  logic [PRIO_W-1:0] prio,
   input  iack_pkg::grp_e    grp,
   input  logic [BP_W-1:0]   bp0,
   input  logic [BP_W-1:0]   bp1,
   output logic [PRIO_W-1:0] level
);
   localparam int SH_W = BP_W + 1;

   initial begin
      if (PRIO_W < 1 || PRIO_W > 16)
         $error("iack_preempt: PRIO_W out of range");
      if ((1 << SH_W) <= PRIO_W)
         $error("iack_preempt: BP_W too narrow for PRIO_W");
   end

   logic [SH_W-1:0] shift;

   // group 0 binary point drops one more bit than group 1
   always_comb begin
      if (grp == iack_pkg::GRP_ZERO) shift = {1'b0, bp0} + SH_W'(1);
      else                           shift = {1'b0, bp1};
   end

   // keep only bits at or above the shift position
   for (genvar gi = 0; gi < PRIO_W; gi++) begin : g_mask
      assign level[gi] = prio[gi] & (SH_W'(gi) >= shift);
   end
endmodule

// File: rtl/iack_gate.sv
module iack_gate #(
   parameter int PRIO_W = 8
) (
   input  logic              cand_vld,
   input  iack_pkg::grp_e    cand_grp,
   input  iack_pkg::grp_e    rd_grp,
   input  logic [PRIO_W-1:0] cand_prio,
   input  logic [PRIO_W-1:0] prio_mask,
   input  logic [PRIO_W-1:0] pre_level,
   input  logic [PRIO_W-1:0] act_hi_prio,
   output logic              grant
);
   logic ok_grp, ok_mask, ok_pre;

   always_comb begin
      ok_grp  = (cand_grp == rd_grp);
      ok_mask = (prio_mask > cand_prio);
      ok_pre  = (act_hi_prio > pre_level);
      grant   = cand_vld & ok_grp & ok_mask & ok_pre;
   end
endmodule

// File: rtl/iack_entry_update.sv
module iack_entry_update #(
   parameter int ID_W    = 16,
   parameter int MAX_SPI = 1019
) (
   input  logic [ID_W-1:0]      vid,
   output iack_pkg::ent_state_e new_state
);
   initial begin
      if (MAX_SPI >= (1 << ID_W))
         $error("iack_entry_update: MAX_SPI does not fit ID_W");
   end

   // message-based IDs above the shared range carry no active state
   always_comb begin
      if (vid <= ID_W'(MAX_SPI)) new_state = iack_pkg::ST_ACT;
      else                       new_state = iack_pkg::ST_NONE;
   end
endmodule

// File: rtl/iack_ctrl.sv
module iack_ctrl #(
   parameter int ID_W     = 16,
   parameter int PRIO_W   = 8,
   parameter int IDX_W    = 4,
   parameter int BP_W     = 3,
   parameter int CODE_W   = 4,
   parameter int G0_CODE  = 8,
   parameter int MAX_SPI  = 1019,
   parameter int SPUR_ID  = 1023
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_vld,
   input  logic [CODE_W-1:0] req_code,
   input  logic              cand_vld,
   input  logic [IDX_W-1:0]  cand_idx,
   input  logic [ID_W-1:0]   cand_vid,
   input  logic [PRIO_W-1:0] cand_prio,
   input  logic              cand_grp,
   input  logic [1:0]        cand_state,
   input  logic [PRIO_W-1:0] prio_mask,
   input  logic [BP_W-1:0]   bp0,
   input  logic [BP_W-1:0]   bp1,
   input  logic [PRIO_W-1:0] act_hi_prio,
   output logic              rsp_vld,
   output logic [ID_W-1:0]   rsp_id,
   output logic              wb_en,
   output logic [IDX_W-1:0]  wb_idx,
   output logic [ID_W-1:0]   wb_vid,
   output logic [PRIO_W-1:0] wb_prio,
   output logic              wb_grp,
   output logic [1:0]        wb_state,
   output logic              set_act_en,
   output logic [PRIO_W-1:0] set_act_prio,
   output logic              set_act_grp
);
   import iack_pkg::*;

   localparam logic [ID_W-1:0] SPUR = ID_W'(SPUR_ID);

   initial begin
      if (SPUR_ID <= MAX_SPI)
         $error("iack_ctrl: spurious ID must lie above shared range");
      if (SPUR_ID >= (1 << ID_W))
         $error("iack_ctrl: SPUR_ID does not fit ID_W");
   end

   grp_e              rd_grp;
   grp_e              c_grp;
   logic [PRIO_W-1:0] pre_level;
   logic              grant;
   ent_state_e        nxt_state;
   logic [1:0]        unused_state;

   assign c_grp        = grp_e'(cand_grp);
   assign unused_state = cand_state;

   iack_grp_decode #(.CODE_W(CODE_W), .G0_CODE(G0_CODE)) u_dec (
      .code (req_code),
      .grp  (rd_grp)
   );

   iack_preempt #(.PRIO_W(PRIO_W), .BP_W(BP_W)) u_pre (
      .prio  (cand_prio),
      .grp   (rd_grp),
      .bp0   (bp0),
      .bp1   (bp1),
      .level (pre_level)
   );

   iack_gate #(.PRIO_W(PRIO_W)) u_gate (
      .cand_vld    (cand_vld),
      .cand_grp    (c_grp),
      .rd_grp      (rd_grp),
      .cand_prio   (cand_prio),
      .prio_mask   (prio_mask),
      .pre_level   (pre_level),
      .act_hi_prio (act_hi_prio),
      .grant       (grant)
   );

   iack_entry_update #(.ID_W(ID_W), .MAX_SPI(MAX_SPI)) u_upd (
      .vid       (cand_vid),
      .new_state (nxt_state)
   );

   // response, write-back and tracker strobe leave together
   logic              r_vld, r_gnt;
   logic [ID_W-1:0]   r_id;
   logic [IDX_W-1:0]  r_idx;
   logic [PRIO_W-1:0] r_prio;
   logic              r_grp;
   logic [1:0]        r_state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_vld   <= 1'b0;
         r_gnt   <= 1'b0;
         r_id    <= '0;
         r_idx   <= '0;
         r_prio  <= '0;
         r_grp   <= 1'b0;
         r_state <= '0;
      end else begin
         r_vld <= req_vld;
         r_gnt <= req_vld & grant;
         if (req_vld) begin
            r_id    <= grant ? cand_vid : SPUR;
            r_idx   <= cand_idx;
            r_prio  <= cand_prio;
            r_grp   <= rd_grp;
            r_state <= nxt_state;
         end
      end
   end

   assign rsp_vld      = r_vld;
   assign rsp_id       = r_id;
   assign wb_en        = r_gnt;
   assign wb_idx       = r_idx;
   assign wb_vid       = r_id;
   assign wb_prio      = r_prio;
   assign wb_grp       = r_grp;
   assign wb_state     = r_state;
   assign set_act_en   = r_gnt;
   assign set_act_prio = r_prio;
   assign set_act_grp  = r_grp;

   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_vld |-> $past(req_vld)); // R8
   AST_REQ_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> rsp_vld); // R8
   AST_WB_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> rsp_vld); // R8
   AST_WB_NEEDS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> $past(cand_vld)); // R2
   AST_WB_GRP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      set_act_en |-> (set_act_grp == $past(cand_grp))); // R3
   AST_UNDER_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      set_act_en |-> (set_act_prio < $past(prio_mask))); // R4
   AST_LPI_NO_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && wb_vid > ID_W'(MAX_SPI)) |-> (wb_state == ST_NONE)); // R7
   AST_SPI_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && wb_vid <= ID_W'(MAX_SPI)) |-> (wb_state == ST_ACT)); // R7
   AST_DENY_SPUR: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && !wb_en) |-> (rsp_id == SPUR)); // R10
endmodule

// File: tb/sim_iack_ctrl.sv
module sim_iack_ctrl;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_vld = 1'b0;
   logic [3:0]  req_code = '0;
   logic        cand_vld = 1'b0;
   logic [3:0]  cand_idx = '0;
   logic [15:0] cand_vid = '0;
   logic [7:0]  cand_prio = '0;
   logic        cand_grp = 1'b0;
   logic [1:0]  cand_state = 2'b01;
   logic [7:0]  prio_mask = '0;
   logic [2:0]  bp0 = '0;
   logic [2:0]  bp1 = '0;
   logic [7:0]  act_hi_prio = 8'hff;
   logic        rsp_vld, wb_en, wb_grp, set_act_en, set_act_grp;
   logic [15:0] rsp_id, wb_vid;
   logic [3:0]  wb_idx;
   logic [7:0]  wb_prio, set_act_prio;
   logic [1:0]  wb_state;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   iack_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_code(req_code),
      .cand_vld(cand_vld), .cand_idx(cand_idx), .cand_vid(cand_vid),
      .cand_prio(cand_prio), .cand_grp(cand_grp), .cand_state(cand_state),
      .prio_mask(prio_mask), .bp0(bp0), .bp1(bp1), .act_hi_prio(act_hi_prio),
      .rsp_vld(rsp_vld), .rsp_id(rsp_id), .wb_en(wb_en), .wb_idx(wb_idx),
      .wb_vid(wb_vid), .wb_prio(wb_prio), .wb_grp(wb_grp), .wb_state(wb_state),
      .set_act_en(set_act_en), .set_act_prio(set_act_prio),
      .set_act_grp(set_act_grp)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // one request cycle; outputs are sampled at the following negedge
   task automatic issue(input logic [3:0] code, input logic cv, input logic [15:0] vid,
                        input logic [7:0] pr, input logic g, input logic [7:0] msk,
                        input logic [2:0] b0, input logic [2:0] b1, input logic [7:0] ah);
      @(negedge clk);
      req_vld = 1'b1; req_code = code; cand_vld = cv; cand_vid = vid;
      cand_prio = pr; cand_grp = g; prio_mask = msk; bp0 = b0; bp1 = b1;
      act_hi_prio = ah; cand_idx = cand_idx + 4'd1;
      @(negedge clk);
      req_vld = 1'b0;
   endtask

   task automatic expect_spur(input string tag);
      chk({tag, " rsp_vld"}, int'(rsp_vld), 1);
      chk({tag, " R10 id"}, int'(rsp_id), 1023);
      chk({tag, " wb_en"}, int'(wb_en), 0);
      chk({tag, " set_act_en"}, int'(set_act_en), 0);
   endtask

   task automatic expect_grant(input string tag, input int vid, input int pr,
                               input int g, input int st);
      chk({tag, " R6 rsp_vld"}, int'(rsp_vld), 1);
      chk({tag, " R6 id"}, int'(rsp_id), vid);
      chk({tag, " R6 wb_en"}, int'(wb_en), 1);
      chk({tag, " R6 wb_idx"}, int'(wb_idx), int'(cand_idx));
      chk({tag, " R6 wb_vid"}, int'(wb_vid), vid);
      chk({tag, " R6 wb_prio"}, int'(wb_prio), pr);
      chk({tag, " R6 set_act_en"}, int'(set_act_en), 1);
      chk({tag, " R6 set_prio"}, int'(set_act_prio), pr);
      chk({tag, " R1 set_grp"}, int'(set_act_grp), g);
      chk({tag, " R6 wb_grp"}, int'(wb_grp), g);
      chk({tag, " R7 wb_state"}, int'(wb_state), st);
   endtask

   task automatic t_reset;
      chk("R9 rsp_vld", int'(rsp_vld), 0);
      chk("R9 wb_en", int'(wb_en), 0);
      chk("R9 set_act_en", int'(set_act_en), 0);
   endtask

   task automatic t_group_decode;
      issue(4'd12, 1'b1, 16'd40, 8'h40, 1'b1, 8'h80, 3'd0, 3'd3, 8'hff);
      expect_grant("R1 grp1", 40, 8'h40, 1, 2);
      issue(4'd8, 1'b1, 16'd5, 8'h20, 1'b0, 8'hf0, 3'd2, 3'd0, 8'hff);
      expect_grant("R1 grp0", 5, 8'h20, 0, 2);
   endtask

   task automatic t_no_cand;
      issue(4'd12, 1'b0, 16'd77, 8'h10, 1'b1, 8'hff, 3'd0, 3'd0, 8'hff);
      expect_spur("R2 nocand");
   endtask

   task automatic t_grp_mismatch;
      issue(4'd8, 1'b1, 16'd33, 8'h10, 1'b1, 8'hff, 3'd0, 3'd0, 8'hff);
      expect_spur("R3 g0read_g1cand");
      issue(4'd3, 1'b1, 16'd34, 8'h10, 1'b0, 8'hff, 3'd0, 3'd0, 8'hff);
      expect_spur("R3 g1read_g0cand");
   endtask

   task automatic t_mask;
      issue(4'd1, 1'b1, 16'd60, 8'h40, 1'b1, 8'h40, 3'd0, 3'd0, 8'hff);
      expect_spur("R4 mask_eq");
      issue(4'd1, 1'b1, 16'd60, 8'h40, 1'b1, 8'h3f, 3'd0, 3'd0, 8'hff);
      expect_spur("R4 mask_below");
      issue(4'd1, 1'b1, 16'd60, 8'h40, 1'b1, 8'h41, 3'd0, 3'd0, 8'hff);
      expect_grant("R4 mask_above", 60, 8'h40, 1, 2);
   endtask

   task automatic t_preempt;
      // group 1, bp1=3: level of 0x4B is 0x48
      issue(4'd2, 1'b1, 16'd90, 8'h4b, 1'b1, 8'hff, 3'd0, 3'd3, 8'h48);
      expect_spur("R5 g1 act_eq_level");
      issue(4'd2, 1'b1, 16'd90, 8'h4b, 1'b1, 8'hff, 3'd0, 3'd3, 8'h49);
      expect_grant("R5 g1 act_above_level", 90, 8'h4b, 1, 2);
      // group 0, bp0=3: four bits cleared, level of 0x4B is 0x40
      issue(4'd8, 1'b1, 16'd91, 8'h4b, 1'b0, 8'hff, 3'd3, 3'd0, 8'h48);
      expect_grant("R5 g0 act_above_level", 91, 8'h4b, 0, 2);
      issue(4'd8, 1'b1, 16'd91, 8'h4b, 1'b0, 8'hff, 3'd3, 3'd0, 8'h40);
      expect_spur("R5 g0 act_eq_level");
      // group 1, bp1=0: no bits cleared
      issue(4'd2, 1'b1, 16'd92, 8'h4b, 1'b1, 8'hff, 3'd3, 3'd0, 8'h4b);
      expect_spur("R5 g1 bp0 act_eq_prio");
   endtask

   task automatic t_lpi;
      issue(4'd4, 1'b1, 16'd1019, 8'h08, 1'b1, 8'hff, 3'd0, 3'd0, 8'hff);
      expect_grant("R7 id1019", 1019, 8'h08, 1, 2);
      issue(4'd4, 1'b1, 16'd1020, 8'h08, 1'b1, 8'hff, 3'd0, 3'd0, 8'hff);
      expect_grant("R7 id1020", 1020, 8'h08, 1, 0);
      issue(4'd4, 1'b1, 16'd8192, 8'h08, 1'b1, 8'hff, 3'd0, 3'd0, 8'hff);
      expect_grant("R7 id8192", 8192, 8'h08, 1, 0);
   endtask

   task automatic t_timing;
      issue(4'd4, 1'b1, 16'd100, 8'h08, 1'b1, 8'hff, 3'd0, 3'd0, 8'hff);
      chk("R8 rsp in cycle", int'(rsp_vld), 1);
      @(negedge clk);
      chk("R8 rsp one cycle", int'(rsp_vld), 0);
      chk("R8 wb one cycle", int'(wb_en), 0);
      chk("R8 set one cycle", int'(set_act_en), 0);
      @(negedge clk);
      chk("R8 idle no rsp", int'(rsp_vld), 0);
   endtask

   initial begin
      #(CLK_P * 100000);
      n_bad++;
      $display("FAIL R8 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_group_decode();
      t_no_cand();
      t_grp_mismatch();
      t_mask();
      t_preempt();
      t_lpi();
      t_timing();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule